// File: doc/BRIEF.md
# Ring Privilege Access Checker

This block mediates every segment access and every procedure transfer made by a processor that runs code at one of four privilege rings. Each cycle it may take one request: an operation code plus a 16-bit segment selector. It looks up the selected descriptor in a small local table. It weighs the current ring, the ring requested inside the selector and the ring of the descriptor. One cycle later it answers with either a grant or a single-cycle fault.

Inward calls go through gate descriptors. A granted gate call moves the current ring to the gate's target ring. It also records the caller's ring on a short internal return stack, and it reports how many stack words the gate asks to be copied onto the privileged stack. The matching return restores the recorded ring.

A separate adjust operation rewrites the requested-ring field of a selector to the caller's ring. An inner-ring routine can apply it to a pointer handed in by an outer caller, so that later checks made on that pointer cannot reach objects the caller itself could not reach. The table is loaded through a write port that only ring 0 may use. An explicit drop operation lets ring 0 code hand control outward to a less privileged ring.

Top module: `ring_access_checker`

## Requirements
- R1: After reset the current ring `cpl` is 0, `rsp_valid` and `rsp_fault` are 0, the return stack is empty, and every table entry holds kind 0 (no descriptor), so any access that selects it faults.
- R2: A request sampled with `req_valid` high at a clock edge is answered after that edge: `rsp_valid` is high for exactly that one cycle, and exactly one of `rsp_grant` or `rsp_fault` is high. Operation codes on `req_op`: 0 read, 1 write, 2 call, 3 return, 4 adjust, 5 drop.
- R3: A read is granted only when the selector index is below ENTRIES and the entry's kind is data (1). The entry's ring must also be numerically greater than or equal to the effective ring, which is the larger of `cpl` and the selector's requested ring. Any other read faults.
- R4: A write follows the rule of R3 and additionally needs the entry's writable bit set.
- R5: A call to a code entry (kind 2) is granted only when its ring equals `cpl` and the selector's requested ring is not greater than `cpl`. It leaves `cpl` unchanged and reports 0 copy words.
- R6: A call to a gate entry (kind 3) is granted when all of the following hold: the gate's ring is at least the effective ring, the gate's target ring is strictly below `cpl`, and the return stack is not full. When granted, `cpl` becomes the target ring, the old `cpl` is pushed, and `rsp_words` shows the gate's copy count. Otherwise the call faults.
- R7: A return with a non-empty return stack is granted and restores `cpl` to the most recently pushed ring. A return with an empty stack faults.
- R8: Adjust is always granted and leaves `cpl` unchanged. `rsp_sel` is the request selector with its requested ring replaced by the larger of that ring and the caller ring. The caller ring is the top of the return stack when a call is outstanding, and `cpl` otherwise.
- R9: Drop takes the new ring from the selector's requested-ring field. It is granted, and sets `cpl` to that ring, only when that ring is not below `cpl` and no call is outstanding. Otherwise it faults.
- R10: A faulting request changes neither `cpl` nor the return stack. Operation codes 6 and 7 always fault.
- R11: A table write on `tbl_we` takes effect only while `cpl` is 0; at any other ring it is ignored. Descriptor word layout: bits 11:10 kind, 9:8 ring, 7 writable, 6:5 gate target ring, 4:0 copy count.
- R12: Selector layout: bits 15:3 index, bit 2 table select (ignored), bits 1:0 requested ring. `rsp_sel` echoes `req_sel` for every operation other than adjust.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present this cycle |
| req_op | input | 3 | Operation code |
| req_sel | input | 16 | Segment selector |
| tbl_we | input | 1 | Descriptor table write enable |
| tbl_idx | input | IDX_W (4) | Table entry to write |
| tbl_desc | input | 12 | Descriptor word to write |
| rsp_valid | output | 1 | Answer present |
| rsp_grant | output | 1 | Request allowed |
| rsp_fault | output | 1 | Request denied, one-cycle pulse |
| rsp_words | output | 5 | Stack words to copy on a granted gate call |
| rsp_sel | output | 16 | Selector, adjusted for adjust requests |
| cpl | output | 2 | Current privilege ring |

## Verification
The bench builds the checker with the default 16-entry table and with a return stack only two entries deep. With only four rings, a chain of inward gate calls can nest at most three deep, so the shallow stack is what makes the stack-full fault of an inward call reachable. Indices up to 19 are generated so that out-of-range selectors occur alongside valid ones. Directed sequences cover the confused-deputy case, where an inner-ring routine adjusts a pointer from an outer caller and is then refused the access. They also cover table writes attempted from ring 3.

// File: rtl/ring_pkg.sv
package ring_pkg;

    typedef logic [1:0] lvl_t;

    typedef enum logic [2:0] {
        OP_READ   = 3'd0,
        OP_WRITE  = 3'd1,
        OP_CALL   = 3'd2,
        OP_RET    = 3'd3,
        OP_ADJUST = 3'd4,
        OP_DROP   = 3'd5,
        OP_RSV6   = 3'd6,
        OP_RSV7   = 3'd7
    } op_e;

    typedef enum logic [1:0] {
        K_NONE = 2'd0,
        K_DATA = 2'd1,
        K_CODE = 2'd2,
        K_GATE = 2'd3
    } kind_e;

    localparam int WORDS_W = 5;
    localparam int SEL_W   = 16;

    typedef struct packed {
        kind_e              kind;
        lvl_t               dpl;
        logic               wr;
        lvl_t               tgt;
        logic [WORDS_W-1:0] words;
    } desc_t;

    localparam int DESC_W = $bits(desc_t);

    typedef struct packed {
        logic [12:0] index;
        logic        ti;
        lvl_t        rpl;
    } sel_t;

    typedef struct packed {
        logic               grant;
        logic               push;
        logic               pop;
        logic               set_cpl;
        lvl_t               new_cpl;
        logic [WORDS_W-1:0] words;
        sel_t               sel_out;
    } verdict_t;

    function automatic lvl_t lvl_max(lvl_t a, lvl_t b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/ring_desc_table.sv
module ring_desc_table
    import ring_pkg::*;
#(
    parameter int ENTRIES = 16,
    localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  lvl_t             cpl,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  desc_t            wr_desc,
    input  logic [IDX_W-1:0] rd_idx,
    output desc_t            rd_desc
);

    desc_t mem [ENTRIES];
    logic  wr_ok;

    assign wr_ok = wr_en && (cpl == 2'd0);

    for (genvar g = 0; g < ENTRIES; g++) begin : g_entry
        always_ff @(posedge clk) begin
            if (rst) begin
                mem[g] <= '0;
            end else if (wr_ok && (wr_idx == IDX_W'(g))) begin
                mem[g] <= wr_desc;
            end
        end

        // R11: outside ring 0 the entry must keep its contents
        p_locked_write_r11: assert property (@(posedge clk) disable iff (rst)
            (wr_en && cpl != 2'd0) |=> $stable(mem[g]));
    end

    assign rd_desc = mem[rd_idx];

endmodule

// File: rtl/ring_ret_stack.sv
module ring_ret_stack
    import ring_pkg::*;
#(
    parameter int DEPTH  = 4,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic clk,
    input  logic rst,
    input  logic push,
    input  logic pop,
    input  lvl_t push_lvl,
    output lvl_t top_lvl,
    output logic empty,
    output logic full
);

    lvl_t             stk [DEPTH];
    logic [CNT_W-1:0] cnt;

    assign empty = (cnt == '0);
    assign full  = (cnt == CNT_W'(DEPTH));

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (push && !pop) begin
            cnt <= cnt + 1'b1;
        end else if (pop && !push) begin
            cnt <= cnt - 1'b1;
        end
    end

    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        always_ff @(posedge clk) begin
            if (rst) begin
                stk[g] <= '0;
            end else if (push && !pop && (cnt == CNT_W'(g))) begin
                stk[g] <= push_lvl;
            end
        end
    end

    always_comb begin
        top_lvl = '0;
        for (int i = 0; i < DEPTH; i++) begin
            if (cnt == CNT_W'(i + 1)) begin
                top_lvl = stk[i];
            end
        end
    end

    // R7: a return is never taken from an empty stack
    p_no_pop_empty_r7: assert property (@(posedge clk) disable iff (rst)
        pop |-> !empty);

    // R6: an inward call never overruns the stack
    p_no_push_full_r6: assert property (@(posedge clk) disable iff (rst)
        push |-> !full);

endmodule

// File: rtl/ring_decide.sv
module ring_decide
    import ring_pkg::*;
(
    input  lvl_t     cpl,
    input  op_e      op,
    input  sel_t     sel,
    input  desc_t    desc,
    input  logic     in_range,
    input  logic     stk_empty,
    input  logic     stk_full,
    input  lvl_t     stk_top,
    output verdict_t v
);

    lvl_t eff;
    lvl_t caller;
    logic data_ok;
    logic gate_ok;

    always_comb begin
        eff     = lvl_max(cpl, sel.rpl);
        caller  = stk_empty ? cpl : stk_top;
        data_ok = in_range && (desc.kind == K_DATA) && (desc.dpl >= eff);
        gate_ok = in_range && (desc.kind == K_GATE) && (desc.dpl >= eff)
                  && (desc.tgt < cpl) && !stk_full;

        v         = '0;
        v.sel_out = sel;

        case (op)
            OP_READ: begin
                v.grant = data_ok;
            end
            OP_WRITE: begin
                v.grant = data_ok && desc.wr;
            end
            OP_CALL: begin
                if (in_range && desc.kind == K_CODE) begin
                    v.grant = (desc.dpl == cpl) && (sel.rpl <= cpl);
                end else begin
                    v.grant   = gate_ok;
                    v.push    = gate_ok;
                    v.set_cpl = gate_ok;
                    v.new_cpl = desc.tgt;
                    v.words   = desc.words;
                end
            end
            OP_RET: begin
                v.grant   = !stk_empty;
                v.pop     = 1'b1;
                v.set_cpl = 1'b1;
                v.new_cpl = stk_top;
            end
            OP_ADJUST: begin
                v.grant       = 1'b1;
                v.sel_out.rpl = lvl_max(sel.rpl, caller);
            end
            OP_DROP: begin
                v.grant   = stk_empty && (sel.rpl >= cpl);
                v.set_cpl = 1'b1;
                v.new_cpl = sel.rpl;
            end
            default: begin
                v.grant = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/ring_access_checker.sv
module ring_access_checker
    import ring_pkg::*;
#(
    parameter int ENTRIES   = 16,
    parameter int RET_DEPTH = 4,
    localparam int IDX_W    = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               req_valid,
    input  logic [2:0]         req_op,
    input  logic [SEL_W-1:0]   req_sel,
    input  logic               tbl_we,
    input  logic [IDX_W-1:0]   tbl_idx,
    input  logic [DESC_W-1:0]  tbl_desc,
    output logic               rsp_valid,
    output logic               rsp_grant,
    output logic               rsp_fault,
    output logic [WORDS_W-1:0] rsp_words,
    output logic [SEL_W-1:0]   rsp_sel,
    output logic [1:0]         cpl
);

    sel_t     sel;
    desc_t    desc;
    logic     in_range;
    lvl_t     stk_top;
    logic     stk_empty;
    logic     stk_full;
    verdict_t v;
    logic     take;

    assign sel      = sel_t'(req_sel);
    assign in_range = (32'(sel.index) < ENTRIES);
    assign take     = req_valid && v.grant;

    ring_desc_table #(.ENTRIES(ENTRIES)) u_table (
        .clk     (clk),
        .rst     (rst),
        .cpl     (cpl),
        .wr_en   (tbl_we),
        .wr_idx  (tbl_idx),
        .wr_desc (desc_t'(tbl_desc)),
        .rd_idx  (sel.index[IDX_W-1:0]),
        .rd_desc (desc)
    );

    ring_ret_stack #(.DEPTH(RET_DEPTH)) u_stack (
        .clk      (clk),
        .rst      (rst),
        .push     (take && v.push),
        .pop      (take && v.pop),
        .push_lvl (cpl),
        .top_lvl  (stk_top),
        .empty    (stk_empty),
        .full     (stk_full)
    );

    ring_decide u_decide (
        .cpl       (cpl),
        .op        (op_e'(req_op)),
        .sel       (sel),
        .desc      (desc),
        .in_range  (in_range),
        .stk_empty (stk_empty),
        .stk_full  (stk_full),
        .stk_top   (stk_top),
        .v         (v)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            cpl       <= 2'd0;
            rsp_valid <= 1'b0;
            rsp_grant <= 1'b0;
            rsp_fault <= 1'b0;
            rsp_words <= '0;
            rsp_sel   <= '0;
        end else begin
            rsp_valid <= req_valid;
            rsp_grant <= take;
            rsp_fault <= req_valid && !v.grant;
            rsp_words <= take ? v.words : '0;
            rsp_sel   <= req_valid ? SEL_W'(v.sel_out) : '0;
            if (take && v.set_cpl) begin
                cpl <= v.new_cpl;
            end
        end
    end

    // R2: every sampled request is answered on the following cycle
    p_answer_r2: assert property (@(posedge clk) disable iff (rst)
        ($past(req_valid) && !$past(rst)) |-> rsp_valid);

    // R10: a denied request leaves the ring where it was
    p_fault_keeps_cpl_r10: assert property (@(posedge clk) disable iff (rst)
        (rsp_fault && !$past(rst)) |-> (cpl == $past(cpl)));

    // R6: the ring only moves inward through a call
    p_inward_by_call_r6: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && cpl < $past(cpl)) |-> ($past(req_valid) && $past(req_op) == 3'(OP_CALL)));

    // R7: a granted return always moves the ring outward
    p_ret_outward_r7: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(req_valid) && $past(req_op) == 3'(OP_RET) && rsp_grant)
        |-> (cpl > $past(cpl)));

    // R6: copy words are reported only together with an inward move
    p_words_inward_r6: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && rsp_words != '0) |-> (cpl < $past(cpl)));

endmodule

// File: tb/sim_ring_access_checker.sv
module sim_ring_access_checker;

    localparam int ENTRIES = 16;
    localparam int DEPTH   = 2;

    logic        clk = 1'b0;
    logic        rst;
    logic        req_valid;
    logic [2:0]  req_op;
    logic [15:0] req_sel;
    logic        tbl_we;
    logic [3:0]  tbl_idx;
    logic [11:0] tbl_desc;
    logic        rsp_valid, rsp_grant, rsp_fault;
    logic [4:0]  rsp_words;
    logic [15:0] rsp_sel;
    logic [1:0]  cpl;

    int n_tests = 0;
    int n_fail  = 0;

    int          m_cpl;
    int          m_stk [DEPTH];
    int          m_dep;
    logic [11:0] m_tbl [ENTRIES];

    ring_access_checker #(.ENTRIES(ENTRIES), .RET_DEPTH(DEPTH)) u0 (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_op(req_op),
        .req_sel(req_sel), .tbl_we(tbl_we), .tbl_idx(tbl_idx),
        .tbl_desc(tbl_desc), .rsp_valid(rsp_valid), .rsp_grant(rsp_grant),
        .rsp_fault(rsp_fault), .rsp_words(rsp_words), .rsp_sel(rsp_sel),
        .cpl(cpl)
    );

    always #5 clk = ~clk;

    task automatic chk(input bit ok, input string tag, input string what,
                       input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: got %0d expected %0d", tag, what, act, exp);
        end
    endtask

    function automatic logic [11:0] mk(input int kind, input int dpl, input int wr,
                                       input int tgt, input int words);
        return {kind[1:0], dpl[1:0], wr[0], tgt[1:0], words[4:0]};
    endfunction

    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    task automatic tbl_write(input int idx, input logic [11:0] d);
        tbl_we   = 1'b1;
        tbl_idx  = idx[3:0];
        tbl_desc = d;
        @(negedge clk);
        tbl_we = 1'b0;
        if (m_cpl == 0) m_tbl[idx] = d;
        chk(rsp_valid == 1'b0, "R2", "valid without request", int'(rsp_valid), 0);
    endtask

    task automatic issue(input int op, input int idx, input bit ti, input int rpl,
                         input string tag);
        logic [11:0] d;
        logic [12:0] ix;
        logic [1:0]  rq;
        logic [15:0] sel_in, exp_sel;
        bit inr, g, push, pop;
        int kind, dpl, wr, tgt, words, eff, caller, ncpl, ew;
        ix   = idx[12:0];
        rq   = rpl[1:0];
        sel_in  = {ix, ti, rq};
        exp_sel = sel_in;
        inr  = idx < ENTRIES;
        d    = inr ? m_tbl[idx] : 12'h000;
        kind = int'(d[11:10]); dpl = int'(d[9:8]); wr = int'(d[7]);
        tgt  = int'(d[6:5]);   words = int'(d[4:0]);
        eff    = imax(m_cpl, rpl);
        caller = (m_dep == 0) ? m_cpl : m_stk[m_dep-1];
        g = 0; push = 0; pop = 0; ncpl = m_cpl; ew = 0;
        case (op)
            0: g = inr && kind == 1 && dpl >= eff;
            1: g = inr && kind == 1 && dpl >= eff && wr == 1;
            2: begin
                if (inr && kind == 2) begin
                    g = (dpl == m_cpl) && (rpl <= m_cpl);
                end else if (inr && kind == 3 && dpl >= eff && tgt < m_cpl && m_dep < DEPTH) begin
                    g = 1; push = 1; ncpl = tgt; ew = words;
                end
            end
            3: if (m_dep > 0) begin g = 1; pop = 1; ncpl = m_stk[m_dep-1]; end
            4: begin
                int nr;
                g  = 1;
                nr = imax(rpl, caller);
                exp_sel[1:0] = nr[1:0];
            end
            5: if (m_dep == 0 && rpl >= m_cpl) begin g = 1; ncpl = rpl; end
            default: g = 0;
        endcase

        req_valid = 1'b1;
        req_op    = op[2:0];
        req_sel   = sel_in;
        @(negedge clk);
        req_valid = 1'b0;

        chk(rsp_valid == 1'b1, "R2", "rsp_valid", int'(rsp_valid), 1);
        chk(rsp_fault == !g, "R2", "rsp_fault", int'(rsp_fault), int'(!g));
        chk(rsp_grant == g, tag, "rsp_grant", int'(rsp_grant), int'(g));
        chk(int'(cpl) == ncpl, tag, "cpl", int'(cpl), ncpl);
        chk(int'(rsp_words) == ew, tag, "rsp_words", int'(rsp_words), ew);
        chk(rsp_sel == exp_sel, tag, "rsp_sel", int'(rsp_sel), int'(exp_sel));

        if (push) begin m_stk[m_dep] = m_cpl; m_dep++; end
        if (pop) m_dep--;
        m_cpl = ncpl;
    endtask

    function automatic string tag_of(input int op, input int idx);
        case (op)
            0: return "R3";
            1: return "R4";
            2: return (idx < ENTRIES && m_tbl[idx][11:10] == 2'd2) ? "R5" : "R6";
            3: return "R7";
            4: return "R8";
            5: return "R9";
            default: return "R10";
        endcase
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL R2 watchdog expired: got 0 expected 1");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        int seed_dummy;
        seed_dummy = $urandom(2024);
        rst = 1'b1; req_valid = 1'b0; req_op = 3'd0; req_sel = 16'h0;
        tbl_we = 1'b0; tbl_idx = 4'd0; tbl_desc = 12'h0;
        m_cpl = 0; m_dep = 0;
        for (int i = 0; i < DEPTH; i++) m_stk[i] = 0;
        for (int i = 0; i < ENTRIES; i++) m_tbl[i] = 12'h000;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1: reset state
        chk(cpl == 2'd0, "R1", "cpl after reset", int'(cpl), 0);
        chk(rsp_valid == 1'b0, "R1", "rsp_valid after reset", int'(rsp_valid), 0);
        chk(rsp_fault == 1'b0, "R1", "rsp_fault after reset", int'(rsp_fault), 0);
        issue(0, 0, 0, 0, "R1");          // empty entry faults
        issue(3, 0, 0, 0, "R1");          // empty return stack

        // R11: load table at ring 0
        tbl_write(1, mk(1, 0, 1, 0, 0));  // data ring 0 writable
        tbl_write(2, mk(1, 3, 0, 0, 0));  // data ring 3 read-only
        tbl_write(3, mk(3, 3, 0, 0, 6));  // gate to ring 0, 6 words
        tbl_write(4, mk(2, 3, 0, 0, 0));  // code ring 3
        tbl_write(5, mk(2, 0, 0, 0, 0));  // code ring 0
        tbl_write(6, mk(3, 3, 0, 2, 3));  // gate to ring 2
        tbl_write(7, mk(3, 3, 0, 1, 2));  // gate to ring 1

        issue(0, 1, 0, 0, "R3");
        issue(1, 2, 0, 3, "R4");          // read-only write faults
        issue(1, 1, 0, 0, "R4");
        issue(0, 20, 0, 0, "R3");         // index out of range
        issue(6, 1, 0, 0, "R10");
        issue(7, 1, 0, 0, "R10");
        issue(3, 1, 0, 0, "R7");          // return with nothing outstanding

        issue(5, 0, 0, 3, "R9");          // drop to ring 3
        issue(5, 0, 0, 1, "R9");          // inward drop faults
        issue(0, 1, 0, 0, "R3");          // ring 0 data from ring 3 faults
        tbl_write(1, mk(1, 3, 1, 0, 0));  // R11: ignored at ring 3
        issue(0, 1, 0, 3, "R11");         // still the ring 0 descriptor

        issue(2, 4, 0, 3, "R5");
        issue(2, 5, 0, 3, "R5");          // direct inward call faults
        issue(2, 3, 0, 3, "R6");          // gate to ring 0

        // confused deputy at ring 0 on behalf of ring 3
        issue(0, 1, 0, 3, "R3");
        issue(4, 1, 0, 0, "R8");          // requested ring becomes 3
        issue(0, 1, 0, 0, "R3");
        issue(0, 1, 1, 0, "R12");         // table-select bit ignored
        issue(5, 0, 0, 3, "R9");          // drop while call outstanding
        issue(2, 3, 0, 3, "R6");          // target not inward
        issue(3, 0, 0, 0, "R7");          // back to ring 3
        issue(4, 2, 0, 1, "R8");          // adjust with nothing outstanding

        // stack depth 2: third inward call faults
        issue(2, 6, 0, 3, "R6");
        issue(2, 7, 0, 3, "R6");
        issue(2, 3, 0, 3, "R6");
        issue(3, 0, 0, 0, "R7");
        issue(3, 0, 0, 0, "R7");
        issue(3, 0, 0, 0, "R7");

        // random mix
        for (int n = 0; n < 1500; n++) begin
            int r, op, idx, rpl;
            bit ti;
            r = int'($urandom % 16);
            if (r < 2) begin
                tbl_write(int'($urandom % 16), 12'($urandom));
            end else begin
                r = int'($urandom % 16);
                if (r < 3) op = 0;
                else if (r < 5) op = 1;
                else if (r < 9) op = 2;
                else if (r < 11) op = 3;
                else if (r < 13) op = 4;
                else if (r < 15) op = 5;
                else op = 6 + int'($urandom % 2);
                idx = int'($urandom % 20);
                rpl = int'($urandom % 4);
                ti  = 1'($urandom % 2);
                issue(op, idx, ti, rpl, tag_of(op, idx));
            end
        end

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule